// File: doc/BRIEF.md
# Program Counter Sequencer with Link Register

This block holds the program counter of a small in-order processor and chooses its next value every clock cycle. The decode stage presents an already decoded operation code together with two register operand values, a signed relative offset and an absolute target address. The sequencer uses these inputs to advance by one, take or skip a relative branch on operand equality or inequality, load an absolute target, enter a subroutine through a register-held address, or come back from it.

A single link register holds the return address. Only the register-indirect jump writes it, storing the address of the instruction that follows the jump. A second indirect jump made before returning replaces the first return address, so calls do not nest. A dedicated operation raises a done flag for exactly one cycle. The program counter advances past that operation in the same way as for a no-operation.

Top module: `seq_pc_sequencer`

## Requirements
- R1: While rst_ni is low, pc_o is 0, done_o is 0 and the link register holds 0. A return issued before any indirect jump therefore leads to address 0.
- R2: Operation code 0 (no-operation), and the unused code 7, make pc_o equal to the old pc_o plus 1 on the next rising clock edge.
- R3: Operation code 1 (branch on equal) makes pc_o equal to pc_o plus the sign-extended 8-bit offset_i when rs_a_i equals rs_b_i. Otherwise it makes pc_o equal to pc_o plus 1.
- R4: Operation code 2 (branch on not equal) makes pc_o equal to pc_o plus the sign-extended offset_i when rs_a_i differs from rs_b_i. Otherwise it makes pc_o equal to pc_o plus 1.
- R5: Operation code 3 (absolute jump) loads pc_o with target_i.
- R6: Operation code 4 (indirect jump) loads pc_o with the low 10 bits of rs_a_i and stores the old pc_o plus 1 in the link register.
- R7: Operation code 5 (return) loads pc_o with the link register and leaves the link register unchanged.
- R8: A second indirect jump issued before a return overwrites the link register, so a later return goes to the instruction after the most recent indirect jump.
- R9: Operation code 6 (done) sets done_o high for exactly the one cycle that follows it and advances pc_o by 1. done_o is low after every other operation.
- R10: All program counter arithmetic wraps modulo 1024, both for the increment and for negative offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded operation code |
| rs_a_i | input | 16 | First register operand value |
| rs_b_i | input | 16 | Second register operand value |
| offset_i | input | 8 | Two's-complement branch offset |
| target_i | input | 10 | Absolute jump address |
| pc_o | output | 10 | Program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sends backward offsets across address 0 and increments past 1023. A sequencer that does not sign-extend the offset, or that saturates, would land far from the expected address there. It issues a return straight after reset and again after two indirect jumps in a row. These cases expose a link register that is not cleared, that stacks several return addresses, or that is written by the return itself. Each branch is run with equal and with unequal operands, which catches swapped conditions. The done flag is checked on both sides of the pulse, which catches a flag that is held high or that never rises.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_BEQ  = 3'd1,
    OP_BNE  = 3'd2,
    OP_JMP  = 3'd3,
    OP_JREG = 3'd4,
    OP_RET  = 3'd5,
    OP_DONE = 3'd6,
    OP_RSVD = 3'd7
  } seq_op_e;
endpackage

// File: rtl/seq_next_pc.sv
module seq_next_pc
  import seq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8
) (
  input  seq_op_e           op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   link_i,
  input  logic [DATA_W-1:0] rs_a_i,
  input  logic [DATA_W-1:0] rs_b_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_inc_o,
  output logic [PC_W-1:0]   pc_nxt_o
);
  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] pc_rel;
  logic            ops_eq;

  assign ofs_ext  = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
  assign pc_rel   = pc_i + ofs_ext;
  assign pc_inc_o = pc_i + PC_W'(1);
  assign ops_eq   = (rs_a_i == rs_b_i);

  always_comb begin
    unique case (op_i)
      OP_BEQ:  pc_nxt_o = ops_eq  ? pc_rel : pc_inc_o;
      OP_BNE:  pc_nxt_o = !ops_eq ? pc_rel : pc_inc_o;
      OP_JMP:  pc_nxt_o = target_i;
      OP_JREG: pc_nxt_o = rs_a_i[PC_W-1:0];
      OP_RET:  pc_nxt_o = link_i;
      default: pc_nxt_o = pc_inc_o;
    endcase
  end
endmodule

// File: rtl/seq_link_reg.sv
module seq_link_reg #(
  parameter int PC_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PC_W-1:0] d_i,
  output logic [PC_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/seq_done_pulse.sv
module seq_done_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= fire_i;
  end
endmodule

// File: rtl/seq_pc_sequencer.sv
module seq_pc_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] rs_a_i,
  input  logic [DATA_W-1:0] rs_b_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              done_o
);
  seq_op_e         op;
  logic [PC_W-1:0] link_q;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_nxt;

  assign op = seq_op_e'(op_i);

  seq_next_pc #(.PC_W(PC_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) i_next (
    .op_i     (op),
    .pc_i     (pc_o),
    .link_i   (link_q),
    .rs_a_i   (rs_a_i),
    .rs_b_i   (rs_b_i),
    .offset_i (offset_i),
    .target_i (target_i),
    .pc_inc_o (pc_inc),
    .pc_nxt_o (pc_nxt)
  );

  // only the indirect jump records a return point; no stack
  seq_link_reg #(.PC_W(PC_W)) i_link (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (op == OP_JREG),
    .d_i    (pc_inc),
    .q_o    (link_q)
  );

  seq_done_pulse i_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (op == OP_DONE),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_o <= '0;
    else         pc_o <= pc_nxt;
  end
endmodule

// File: rtl/seq_pc_sequencer_chk.sv
module seq_pc_sequencer_chk #(
  parameter int PC_W   = 10,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] rs_a_i,
  input logic [DATA_W-1:0] rs_b_i,
  input logic [OFS_W-1:0]  offset_i,
  input logic [PC_W-1:0]   target_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              done_o
);
  logic [PC_W-1:0] pc_plus1;
  logic [PC_W-1:0] pc_plus_ofs;
  assign pc_plus1    = pc_o + PC_W'(1);
  assign pc_plus_ofs = pc_o + PC_W'($signed(offset_i));

  // R2
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd7) |=> pc_o == $past(pc_plus1));
  // R3
  a_r3_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && rs_a_i == rs_b_i) |=> pc_o == $past(pc_plus_ofs));
  // R4
  a_r4_bne_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && rs_a_i != rs_b_i) |=> pc_o == $past(pc_plus_ofs));
  // R5
  a_r5_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd3 |=> pc_o == $past(target_i));
  // R6
  a_r6_jreg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd4 |=> pc_o == $past(rs_a_i[PC_W-1:0]));
  // R7
  a_r7_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 ##1 op_i == 3'd5) |=> pc_o == $past(pc_plus1, 2));
  // R9
  a_r9_done_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd6 |=> done_o);
  a_r9_done_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i != 3'd6 |=> !done_o);
endmodule

bind seq_pc_sequencer seq_pc_sequencer_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .OFS_W(OFS_W)
) i_chk (.*);

// File: tb/test_seq_pc_sequencer.sv
module test_seq_pc_sequencer;
  localparam logic [2:0] C_NOP = 3'd0, C_BEQ = 3'd1, C_BNE = 3'd2, C_JMP = 3'd3,
                         C_JREG = 3'd4, C_RET = 3'd5, C_DONE = 3'd6, C_RSVD = 3'd7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] rs_a_i = '0;
  logic [15:0] rs_b_i = '0;
  logic [7:0]  offset_i = '0;
  logic [9:0]  target_i = '0;
  logic [9:0]  pc_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  seq_pc_sequencer i_seq_pc_sequencer (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one operation, wait for the edge, return the values after it
  task automatic issue(logic [2:0] op, int a, int b, int ofs, int tgt);
    op_i = op; rs_a_i = 16'(a); rs_b_i = 16'(b);
    offset_i = 8'(ofs); target_i = 10'(tgt);
    @(posedge clk_i);
    #1;
    op_i = C_NOP;
  endtask

  task automatic t_reset();
    chk("R1 pc", int'(pc_o), 0);
    chk("R1 done", int'(done_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    issue(C_RET, 0, 0, 0, 0);
    chk("R1 link zero", int'(pc_o), 0);
  endtask

  task automatic t_advance();
    issue(C_JMP, 0, 0, 0, 40);
    issue(C_NOP, 0, 0, 0, 0);
    chk("R2 nop", int'(pc_o), 41);
    issue(C_RSVD, 0, 0, 0, 999);
    chk("R2 code7", int'(pc_o), 42);
  endtask

  task automatic t_beq();
    issue(C_JMP, 0, 0, 0, 100);
    issue(C_BEQ, 7, 7, 5, 0);
    chk("R3 beq taken", int'(pc_o), 105);
    issue(C_BEQ, 7, 8, 5, 0);
    chk("R3 beq not taken", int'(pc_o), 106);
    issue(C_BEQ, 3, 3, -6, 0);
    chk("R3 beq back", int'(pc_o), 100);
  endtask

  task automatic t_bne();
    issue(C_JMP, 0, 0, 0, 200);
    issue(C_BNE, 1, 2, 127, 0);
    chk("R4 bne taken", int'(pc_o), 327);
    issue(C_BNE, 9, 9, 20, 0);
    chk("R4 bne not taken", int'(pc_o), 328);
    issue(C_BNE, 16'h8000, 0, -128, 0);
    chk("R4 bne back", int'(pc_o), 200);
  endtask

  task automatic t_jump_wrap();
    issue(C_JMP, 0, 0, 0, 1023);
    chk("R5 jump", int'(pc_o), 1023);
    issue(C_NOP, 0, 0, 0, 0);
    chk("R10 inc wrap", int'(pc_o), 0);
    issue(C_JMP, 0, 0, 0, 2);
    issue(C_BEQ, 0, 0, -4, 0);
    chk("R10 ofs wrap", int'(pc_o), 1022);
  endtask

  task automatic t_call();
    issue(C_JMP, 0, 0, 0, 50);
    issue(C_JREG, 16'hFD2C, 0, 0, 0);
    chk("R6 jreg low bits", int'(pc_o), 300);
    issue(C_NOP, 0, 0, 0, 0);
    issue(C_RET, 0, 0, 0, 0);
    chk("R7 return", int'(pc_o), 51);
    issue(C_RET, 0, 0, 0, 0);
    chk("R7 link kept", int'(pc_o), 51);
  endtask

  task automatic t_nested();
    issue(C_JMP, 0, 0, 0, 10);
    issue(C_JREG, 200, 0, 0, 0);
    issue(C_JREG, 400, 0, 0, 0);
    chk("R8 second jreg", int'(pc_o), 400);
    issue(C_RET, 0, 0, 0, 0);
    chk("R8 overwrite", int'(pc_o), 201);
  endtask

  task automatic t_done();
    issue(C_JMP, 0, 0, 0, 600);
    chk("R9 low before", int'(done_o), 0);
    issue(C_DONE, 0, 0, 0, 0);
    chk("R9 pulse", int'(done_o), 1);
    chk("R9 pc", int'(pc_o), 601);
    issue(C_NOP, 0, 0, 0, 0);
    chk("R9 one cycle", int'(done_o), 0);
  endtask

  initial begin
    #(4 * 2000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_advance();
    t_beq();
    t_bne();
    t_jump_wrap();
    t_call();
    t_nested();
    t_done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule